// File: doc/BRIEF.md
# Parallel-In Serial-Out FIFO

This block queues 16-bit words that arrive on a parallel write port and sends them out one bit at a time on a single serial line. A one-cycle write strobe stores a word. A one-cycle shift strobe moves the next bit onto the serial output. Both ports run on one system clock. An order input chooses, for each word, whether its least or most significant bit leaves first.

The buffer depth is a parameter and must be a power of two. The default is 1024; 256 and 512 are the other usual settings. Writes and shifts can happen in the same cycle. A write attempted while the queue is full is dropped, and a shift attempted while it is empty is dropped. Neither attempt changes the stored state. A word stays counted as stored until its last bit has left, so the empty and full outputs follow whole words. Status thresholds other than empty and full are produced outside this block.

Top module: `piso_fifo`

## Requirements
- R1: While reset is held and on the first cycle after it, `empty` is 1, `full` is 0 and `ser_out` is 0.
- R2: A write strobe while not full stores `wr_data`, and `empty` reads 0 on the cycle after the strobe.
- R3: `full` is 1 while DEPTH words are held, counting a partly shifted word. A write strobe while full is dropped, so that word never appears on the output.
- R4: Each shift strobe while not empty puts exactly one new bit on `ser_out`, and that bit is visible on the cycle after the strobe.
- R5: With `msb_first` = 0 a word leaves bit 0 first, then bits 1 to 15 in order. With `msb_first` = 1 it leaves bit 15 first, then bits 14 down to 0.
- R6: `msb_first` is sampled only on the shift that sends a word's first bit. A change during the rest of that word has no effect on its order.
- R7: A word is removed only when its 16th bit is shifted. `full` drops on the cycle after that shift, and `empty` rises on the cycle after the last bit of the last word.
- R8: A shift strobe while empty is dropped: `ser_out` keeps its value and no later word is skipped or altered.
- R9: Writes in the same cycles as shifts are accepted, and words leave in the order they were written.
- R10: Without a shift strobe, `ser_out` holds its last value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_stb | input | 1 | Write strobe, one cycle per word |
| wr_data | input | 16 | Word to store |
| shift_stb | input | 1 | Shift strobe, one cycle per bit |
| msb_first | input | 1 | Bit order for the next word: 0 = LSB first, 1 = MSB first |
| ser_out | output | 1 | Serial data bit (registered) |
| empty | output | 1 | No word held |
| full | output | 1 | DEPTH words held |

## Verification
Every result is one register stage behind its strobe. `ser_out` shows a bit one cycle after the shift strobe that sent it, `empty` falls one cycle after a write, and `full` or `empty` change one cycle after a word's 16th shift. The bench drives each strobe for exactly one cycle, starting on a falling edge. It reads the outputs on the next falling edge, which comes right after the single rising edge where the registers update. Boundary checks therefore compare the flags one cycle after the 15th and after the 16th bit of a word. This shows the flags change on the word's last bit and not on an earlier one.

// File: rtl/piso_pkg.sv
package piso_pkg;

   typedef enum logic {
      ORD_LSB = 1'b0,
      ORD_MSB = 1'b1
   } bit_order_e;

   // bit taken from the edge of a word that matches the chosen order
   function automatic logic edge_bit(input logic [15:0] w, input bit_order_e ord);
      return (ord == ORD_MSB) ? w[15] : w[0];
   endfunction

endpackage

// File: rtl/piso_store.sv
module piso_store #(
   parameter int WORD_W = 16,
   parameter int DEPTH  = 1024
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              push,
   input  logic [WORD_W-1:0] push_data,
   input  logic              pop,
   output logic [WORD_W-1:0] head_word
);
   localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

   logic [WORD_W-1:0] mem [DEPTH];
   logic [PTR_W-1:0]  wr_ptr;
   logic [PTR_W-1:0]  rd_ptr;

   generate
      if ((DEPTH & (DEPTH - 1)) != 0) begin : g_depth_bad
         $error("piso_store: DEPTH must be a power of two");
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (push) mem[wr_ptr] <= push_data;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
      end else begin
         if (push) wr_ptr <= wr_ptr + 1'b1;
         if (pop)  rd_ptr <= rd_ptr + 1'b1;
      end
   end

   assign head_word = mem[rd_ptr];

endmodule

// File: rtl/piso_occupancy.sv
module piso_occupancy #(
   parameter int DEPTH = 1024
) (
   input  logic clk,
   input  logic rst_n,
   input  logic push_req,
   input  logic pop,
   output logic push_ok,
   output logic empty,
   output logic full
);
   localparam int CNT_W = $clog2(DEPTH + 1);
   localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(DEPTH);

   logic [CNT_W-1:0] count;

   generate
      if (DEPTH < 2) begin : g_depth_small
         $error("piso_occupancy: DEPTH must be at least 2");
      end
   endgenerate

   assign full    = (count == CNT_MAX);
   assign empty   = (count == '0);
   assign push_ok = push_req && !full;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         count <= '0;
      end else begin
         case ({push_ok, pop})
            2'b10:   count <= count + 1'b1;
            2'b01:   count <= count - 1'b1;
            default: count <= count;
         endcase
      end
   end

endmodule

// File: rtl/piso_serializer.sv
module piso_serializer
   import piso_pkg::*;
#(
   parameter int WORD_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              shift_req,
   input  logic              empty,
   input  logic              msb_first,
   input  logic [WORD_W-1:0] head_word,
   output logic              ser_out,
   output logic              pop
);
   localparam int IDX_W = $clog2(WORD_W);
   localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(WORD_W - 1);

   logic [WORD_W-1:0] sreg;
   logic [IDX_W-1:0]  bcnt;
   bit_order_e        ord_q;
   bit_order_e        ord_new;
   logic              ser_q;
   logic              shift_ok;

   generate
      if (WORD_W != 16) begin : g_width_bad
         $error("piso_serializer: WORD_W must be 16");
      end
   endgenerate

   assign shift_ok = shift_req && !empty;
   assign pop      = shift_ok && (bcnt == LAST_IDX);
   assign ord_new  = bit_order_e'(msb_first);
   assign ser_out  = ser_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sreg  <= '0;
         bcnt  <= '0;
         ord_q <= ORD_LSB;
         ser_q <= 1'b0;
      end else if (shift_ok) begin
         if (bcnt == '0) begin
            ord_q <= ord_new;
            ser_q <= edge_bit(head_word, ord_new);
            sreg  <= (ord_new == ORD_MSB) ? (head_word << 1) : (head_word >> 1);
         end else begin
            ser_q <= edge_bit(sreg, ord_q);
            sreg  <= (ord_q == ORD_MSB) ? (sreg << 1) : (sreg >> 1);
         end
         bcnt <= (bcnt == LAST_IDX) ? '0 : bcnt + 1'b1;
      end
   end

endmodule

// File: rtl/piso_fifo.sv
module piso_fifo #(
   parameter int WORD_W = 16,
   parameter int DEPTH  = 1024
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_stb,
   input  logic [WORD_W-1:0] wr_data,
   input  logic              shift_stb,
   input  logic              msb_first,
   output logic              ser_out,
   output logic              empty,
   output logic              full
);
   logic              push_ok;
   logic              pop;
   logic [WORD_W-1:0] head_word;

   piso_occupancy #(.DEPTH(DEPTH)) u_occ (
      .clk(clk), .rst_n(rst_n), .push_req(wr_stb), .pop(pop),
      .push_ok(push_ok), .empty(empty), .full(full)
   );

   piso_store #(.WORD_W(WORD_W), .DEPTH(DEPTH)) u_store (
      .clk(clk), .rst_n(rst_n), .push(push_ok), .push_data(wr_data),
      .pop(pop), .head_word(head_word)
   );

   piso_serializer #(.WORD_W(WORD_W)) u_ser (
      .clk(clk), .rst_n(rst_n), .shift_req(shift_stb), .empty(empty),
      .msb_first(msb_first), .head_word(head_word),
      .ser_out(ser_out), .pop(pop)
   );

endmodule

// File: rtl/piso_fifo_chk.sv
module piso_fifo_chk (
   input logic clk,
   input logic rst_n,
   input logic wr_stb,
   input logic shift_stb,
   input logic ser_out,
   input logic empty,
   input logic full
);
   // R3
   flags_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(empty && full));

   // R3
   full_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (full && wr_stb && !shift_stb) |=> full);

   // R2
   write_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (empty && wr_stb) |=> !empty);

   // R8
   empty_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (empty && !wr_stb) |=> (empty && $stable(ser_out)));

   // R10
   idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !shift_stb |=> $stable(ser_out));

endmodule

bind piso_fifo piso_fifo_chk u_chk (
   .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb), .shift_stb(shift_stb),
   .ser_out(ser_out), .empty(empty), .full(full)
);

// File: tb/tb_piso_fifo.sv
module tb_piso_fifo;
   localparam int DEPTH = 1024;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_stb = 1'b0;
   logic [15:0] wr_data = '0;
   logic        shift_stb = 1'b0;
   logic        msb_first = 1'b0;
   logic        ser_out, empty, full;

   int n_checks = 0;
   int n_fail   = 0;
   bit done     = 1'b0;
   logic [15:0] model[$];

   always #2 clk = ~clk;

   piso_fifo #(.WORD_W(16), .DEPTH(DEPTH)) dut (
      .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb), .wr_data(wr_data),
      .shift_stb(shift_stb), .msb_first(msb_first),
      .ser_out(ser_out), .empty(empty), .full(full)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   // one cycle: inputs set after a falling edge, outputs read on the next one
   task automatic tick(input logic w, input logic [15:0] d, input logic s, input logic dir);
      wr_stb = w; wr_data = d; shift_stb = s; msb_first = dir;
      @(negedge clk);
      wr_stb = 1'b0; shift_stb = 1'b0;
   endtask

   task automatic put(input logic [15:0] d);
      if (!full) model.push_back(d);
      tick(1'b1, d, 1'b0, msb_first);
   endtask

   // shift one whole word; optional write on the first bit; optional order flip after bit 3
   task automatic take(input logic dir, input bit flip, input bit wr_now, input logic [15:0] wd,
                       input string req);
      logic [15:0] w;
      w = model.pop_front();
      for (int i = 0; i < 16; i++) begin
         logic d;
         d = (flip && i > 3) ? ~dir : dir;
         if (wr_now && i == 0) model.push_back(wd);
         tick(wr_now && i == 0, wd, 1'b1, d);
         check(req, ser_out, dir ? w[15-i] : w[i]);
      end
   endtask

   task automatic do_reset();
      rst_n = 1'b0;
      model.delete();
      repeat (3) @(negedge clk);
      check("R1 empty in reset", empty, 1);
      check("R1 full in reset", full, 0);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 empty", empty, 1);
      check("R1 full", full, 0);
      check("R1 ser_out", ser_out, 0);
   endtask

   task automatic t_basic_orders();
      put(16'hA5C3);
      check("R2 empty after write", empty, 0);
      take(1'b0, 0, 0, '0, "R5 lsb first");
      check("R7 empty after last bit", empty, 1);
      put(16'h1E2D);
      take(1'b1, 0, 0, '0, "R5 msb first");
      repeat (3) tick(1'b0, '0, 1'b0, 1'b0);
      check("R10 hold", ser_out, 16'h1E2D & 1);
   endtask

   task automatic t_dir_midword();
      put(16'hF00D);
      take(1'b1, 1, 0, '0, "R6 msb kept after flip");
      put(16'h3C96);
      take(1'b0, 1, 0, '0, "R6 lsb kept after flip");
   endtask

   task automatic t_empty_shift();
      logic hold;
      hold = ser_out;
      repeat (4) begin
         tick(1'b0, '0, 1'b1, 1'b1);
         check("R8 ser_out held when empty", ser_out, hold);
      end
      check("R8 still empty", empty, 1);
      put(16'h8001);
      take(1'b1, 0, 0, '0, "R8 next word intact");
   endtask

   task automatic t_full();
      for (int i = 0; i < DEPTH; i++) put(16'($urandom));
      check("R3 full at DEPTH", full, 1);
      put(16'hDEAD);
      check("R3 still full after dropped write", full, 1);
      check("R3 model size", model.size(), DEPTH);
      begin
         logic [15:0] w;
         w = model.pop_front();
         for (int i = 0; i < 16; i++) begin
            tick(1'b0, '0, 1'b1, 1'b0);
            check("R4 bit of first word", ser_out, w[i]);
            if (i == 14) check("R7 full before 16th bit", full, 1);
         end
         check("R7 full clears after 16th bit", full, 0);
      end
      while (model.size() > 1) take(model.size() % 2, 0, 0, '0, "R3 drain order");
      take(1'b0, 0, 0, '0, "R3 last word is not the dropped one");
      check("R7 empty after drain", empty, 1);
   endtask

   task automatic t_concurrent();
      put(16'h0F0F);
      take(1'b0, 0, 1, 16'h7A7A, "R9 shift with write");
      check("R9 word queued", empty, 0);
      take(1'b1, 0, 1, 16'h5511, "R9 second");
      take(1'b0, 0, 0, '0, "R9 third");
      check("R9 empty", empty, 1);
   endtask

   task automatic t_random();
      for (int r = 0; r < 40; r++) begin
         int k;
         k = 1 + ($urandom % 5);
         for (int j = 0; j < k; j++) put(16'($urandom));
         while (model.size() > 0)
            take($urandom % 2, 0, ($urandom % 3) == 0 && model.size() < 8,
                 16'($urandom), "R5 random stream");
      end
      check("R7 empty after stream", empty, 1);
   endtask

   initial begin
      #(4 * 200000);
      if (!done) begin
         n_checks++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
         $finish;
      end
   end

   initial begin
      @(negedge clk);
      do_reset();
      t_basic_orders();
      t_dir_midword();
      t_empty_shift();
      t_full();
      t_concurrent();
      t_random();
      do_reset();
      done = 1'b1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end

endmodule